// File: doc/BRIEF.md
# Direction-Selectable Cascadable Segment Shift-Latch

This block is the serial front end of a segment display driver. A long shift chain, `2*PAIRS` bits organised as `PAIRS` segment pairs, takes serial data one bit per rising edge of the shift clock. A parallel holding register behind the chain drives the segment data. The holding register copies the whole chain on either of two load strobes. One strobe is active-high and loads on its rising edge. The other is active-low and loads on its falling edge.

The block has two pad sides, A and B. Each side has a serial data input, a shift-clock pad, two load-strobe pads and a multiplex-clock pad. A static strap picks the side that receives data and clocks:

- With the strap at 1, side A is the input side. Data enters at the high end of the chain (pair `PAIRS`, bit 2) and moves toward index 0.
- With the strap at 0, side B is the input side. Data enters at index 0 (pair 1, bit 1) and moves upward.

Each selected input pad is repeated on the pad of the same kind on the opposite side. This lets chips be chained with short routing. The bit that falls off the far end of the chain is retimed by a falling-edge flop. It drives both serial outputs and feeds the next chip in the cascade.

Chain bit index for pair `p`, bit `b` (both counted from 1) is `2*(p-1)+(b-1)`.

Top module: `seg_shift_latch`

## Requirements
- R1: While `rst_n` is low, `seg_q`, `sdo_a` and `sdo_b` are all zero, and the shift chain is cleared. A load right after reset therefore gives all zeros.
- R2: With `dir_strap`=1, each rising edge of `sclk_a_i` shifts the chain. Bit index `i` takes the old value of index `i+1`, and the top index `2*PAIRS-1` takes `sdi_a`.
- R3: With `dir_strap`=0, each rising edge of `sclk_b_i` shifts the chain. Bit index `i` takes the old value of index `i-1`, and index 0 takes `sdi_b`.
- R4: `sdo_a` and `sdo_b` are always equal. Both take the chain end bit on the falling edge of the selected shift clock: index 0 when `dir_strap`=1, index `2*PAIRS-1` when `dir_strap`=0. They do not change at the rising edge.
- R5: The selected shift clock is repeated on the opposite side's clock output: `sclk_b_o` when `dir_strap`=1, `sclk_a_o` when `dir_strap`=0. The clock output on the input side is held at 0.
- R6: A rising edge on the selected `ldp` input, while the selected `ldn` is high, copies the whole chain into `seg_q`.
- R7: A falling edge on the selected `ldn` input, while the selected `ldp` is low, copies the whole chain into `seg_q`. Both strobes active at once (ldp high and ldn low) is disallowed.
- R8: Shifting alone never changes `seg_q`.
- R9: The selected `ldp`, `ldn` and `mclk` inputs are repeated on the opposite side's outputs. The outputs on the input side sit at idle levels: 0 for ldp, 1 for ldn and 0 for mclk.
- R10: Pads of the non-selected side have no effect on the chain, `seg_q`, `sdo_a/sdo_b` or any pad output.
- R11: `dir_strap` is static. It changes only while `rst_n` is low, and a new value applies after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_strap | input | 1 | Static side select: 1 = side A input, 0 = side B input |
| sdi_a | input | 1 | Serial data, side A |
| sdi_b | input | 1 | Serial data, side B |
| sclk_a_i | input | 1 | Shift clock pad input, side A |
| sclk_b_i | input | 1 | Shift clock pad input, side B |
| sclk_a_o | output | 1 | Shift clock repeat, side A |
| sclk_b_o | output | 1 | Shift clock repeat, side B |
| sdo_a | output | 1 | Cascade serial data, side A |
| sdo_b | output | 1 | Cascade serial data, side B |
| ldp_a_i | input | 1 | Active-high load strobe input, side A |
| ldp_b_i | input | 1 | Active-high load strobe input, side B |
| ldp_a_o | output | 1 | Active-high load repeat, side A |
| ldp_b_o | output | 1 | Active-high load repeat, side B |
| ldn_a_i | input | 1 | Active-low load strobe input, side A |
| ldn_b_i | input | 1 | Active-low load strobe input, side B |
| ldn_a_o | output | 1 | Active-low load repeat, side A |
| ldn_b_o | output | 1 | Active-low load repeat, side B |
| mclk_a_i | input | 1 | Multiplex clock input, side A |
| mclk_b_i | input | 1 | Multiplex clock input, side B |
| mclk_a_o | output | 1 | Multiplex clock repeat, side A |
| mclk_b_o | output | 1 | Multiplex clock repeat, side B |
| seg_q | output | 2*PAIRS | Holding register, index 2*(p-1)+(b-1) |

## Verification
The hardest situation to reach from the ports is the half-period retiming of the cascade output. It must be seen to stay put across the rising edge and move only at the falling edge. The stimulus produces each clock pulse in a task and samples between the two edges and again after the falling edge.

A strap change is the other hard case, because it is legal only inside reset. The bench changes `dir_strap` with reset asserted and gives one pulse of the newly selected clock before it releases reset. It then runs the mirrored shift pattern against its queue model.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic {
        SIDE_B_IN = 1'b0,
        SIDE_A_IN = 1'b1
    } side_e;

    localparam int PAD_KINDS = 4;
    localparam int PK_SCLK   = 0;
    localparam int PK_LDP    = 1;
    localparam int PK_LDN    = 2;
    localparam int PK_MCLK   = 3;
    localparam logic [PAD_KINDS-1:0] PAD_IDLE = 4'b0100;
endpackage

// File: rtl/seg_pad_fwd.sv
module seg_pad_fwd
    import seg_pkg::*;
#(
    parameter logic IDLE = 1'b0
) (
    input  side_e side,
    input  logic  a_i,
    input  logic  b_i,
    output logic  sel,
    output logic  a_o,
    output logic  b_o
);
    always_comb begin
        unique case (side)
            SIDE_A_IN: begin
                sel = a_i;
                b_o = a_i;
                a_o = IDLE;
            end
            SIDE_B_IN: begin
                sel = b_i;
                a_o = b_i;
                b_o = IDLE;
            end
            default: begin
                sel = 1'b0;
                a_o = IDLE;
                b_o = IDLE;
            end
        endcase
    end
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
    import seg_pkg::*;
#(
    parameter int PAIRS = 140,
    localparam int NBITS = 2 * PAIRS
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  side_e            side,
    input  logic             din,
    output logic [NBITS-1:0] chain,
    output logic             end_bit
);
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            unique case (side)
                SIDE_A_IN: chain <= {din, chain[NBITS-1:1]};
                SIDE_B_IN: chain <= {chain[NBITS-2:0], din};
                default:   chain <= chain;
            endcase
        end
    end

    always_comb begin
        unique case (side)
            SIDE_A_IN: end_bit = chain[0];
            SIDE_B_IN: end_bit = chain[NBITS-1];
            default:   end_bit = 1'b0;
        endcase
    end

    // R2
    shift_down_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (side == SIDE_A_IN) |=> (chain[NBITS-1] == $past(din)) &&
                                (chain[NBITS-2:0] == $past(chain[NBITS-1:1])));

    // R3
    shift_up_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (side == SIDE_B_IN) |=> (chain[0] == $past(din)) &&
                                (chain[NBITS-1:1] == $past(chain[NBITS-2:0])));
endmodule

// File: rtl/seg_cascade_out.sv
module seg_cascade_out (
    input  logic sclk,
    input  logic rst_n,
    input  logic end_bit,
    output logic do_q
);
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) do_q <= 1'b0;
        else        do_q <= end_bit;
    end

    // R4
    cascade_out_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        do_q == end_bit);
endmodule

// File: rtl/seg_hold_reg.sv
module seg_hold_reg #(
    parameter int NBITS = 280
) (
    input  logic             ld_evt,
    input  logic             rst_n,
    input  logic [NBITS-1:0] chain,
    output logic [NBITS-1:0] seg_q
);
    always_ff @(posedge ld_evt or negedge rst_n) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= chain;
    end
endmodule

// File: rtl/seg_shift_latch.sv
module seg_shift_latch
    import seg_pkg::*;
#(
    parameter int PAIRS = 140,
    localparam int NBITS = 2 * PAIRS
) (
    input  logic             rst_n,
    input  logic             dir_strap,
    input  logic             sdi_a,
    input  logic             sdi_b,
    input  logic             sclk_a_i,
    input  logic             sclk_b_i,
    output logic             sclk_a_o,
    output logic             sclk_b_o,
    output logic             sdo_a,
    output logic             sdo_b,
    input  logic             ldp_a_i,
    input  logic             ldp_b_i,
    output logic             ldp_a_o,
    output logic             ldp_b_o,
    input  logic             ldn_a_i,
    input  logic             ldn_b_i,
    output logic             ldn_a_o,
    output logic             ldn_b_o,
    input  logic             mclk_a_i,
    input  logic             mclk_b_i,
    output logic             mclk_a_o,
    output logic             mclk_b_o,
    output logic [NBITS-1:0] seg_q
);
    side_e side;
    logic [PAD_KINDS-1:0] pa_i, pb_i, pa_o, pb_o, psel;
    logic sdi_sel, sclk, ld_evt, end_bit, do_q;
    logic [NBITS-1:0] chain;

    assign side = side_e'(dir_strap);

    assign pa_i = {mclk_a_i, ldn_a_i, ldp_a_i, sclk_a_i};
    assign pb_i = {mclk_b_i, ldn_b_i, ldp_b_i, sclk_b_i};

    for (genvar k = 0; k < PAD_KINDS; k++) begin : g_pad
        seg_pad_fwd #(.IDLE(PAD_IDLE[k])) u_fwd (
            .side (side),
            .a_i  (pa_i[k]),
            .b_i  (pb_i[k]),
            .sel  (psel[k]),
            .a_o  (pa_o[k]),
            .b_o  (pb_o[k])
        );
    end

    assign {mclk_a_o, ldn_a_o, ldp_a_o, sclk_a_o} = pa_o;
    assign {mclk_b_o, ldn_b_o, ldp_b_o, sclk_b_o} = pb_o;

    assign sclk    = psel[PK_SCLK];
    assign sdi_sel = (side == SIDE_A_IN) ? sdi_a : sdi_b;
    assign ld_evt  = psel[PK_LDP] | ~psel[PK_LDN];

    seg_shift_chain #(.PAIRS(PAIRS)) u_chain (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .side    (side),
        .din     (sdi_sel),
        .chain   (chain),
        .end_bit (end_bit)
    );

    seg_cascade_out u_cas (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .end_bit (end_bit),
        .do_q    (do_q)
    );

    seg_hold_reg #(.NBITS(NBITS)) u_hold (
        .ld_evt (ld_evt),
        .rst_n  (rst_n),
        .chain  (chain),
        .seg_q  (seg_q)
    );

    assign sdo_a = do_q;
    assign sdo_b = do_q;

    // R7
    strobe_excl_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        !(psel[PK_LDP] && !psel[PK_LDN]));

    // R11
    dir_static_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $stable(dir_strap));
endmodule

// File: tb/sim_seg_shift_latch.sv
module sim_seg_shift_latch;
    localparam int CLK_PERIOD = 20;
    localparam int PAIRS = 140;
    localparam int N = 2 * PAIRS;

    logic rst_n, dir_strap, sdi_a, sdi_b, sclk_a_i, sclk_b_i;
    logic ldp_a_i, ldp_b_i, ldn_a_i, ldn_b_i, mclk_a_i, mclk_b_i;
    logic sclk_a_o, sclk_b_o, sdo_a, sdo_b, ldp_a_o, ldp_b_o;
    logic ldn_a_o, ldn_b_o, mclk_a_o, mclk_b_o;
    logic [N-1:0] seg_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit ref_q[$];
    logic ref_do;
    logic [N-1:0] ref_seg;

    seg_shift_latch #(.PAIRS(PAIRS)) u0 (
        .rst_n(rst_n), .dir_strap(dir_strap), .sdi_a(sdi_a), .sdi_b(sdi_b),
        .sclk_a_i(sclk_a_i), .sclk_b_i(sclk_b_i), .sclk_a_o(sclk_a_o), .sclk_b_o(sclk_b_o),
        .sdo_a(sdo_a), .sdo_b(sdo_b), .ldp_a_i(ldp_a_i), .ldp_b_i(ldp_b_i),
        .ldp_a_o(ldp_a_o), .ldp_b_o(ldp_b_o), .ldn_a_i(ldn_a_i), .ldn_b_i(ldn_b_i),
        .ldn_a_o(ldn_a_o), .ldn_b_o(ldn_b_o), .mclk_a_i(mclk_a_i), .mclk_b_i(mclk_b_i),
        .mclk_a_o(mclk_a_o), .mclk_b_o(mclk_b_o), .seg_q(seg_q)
    );

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ref_q[i];
        return v;
    endfunction

    function automatic logic model_end();
        return dir_strap ? ref_q[0] : ref_q[N-1];
    endfunction

    task automatic model_clear();
        ref_q.delete();
        for (int i = 0; i < N; i++) ref_q.push_back(1'b0);
        ref_do = 1'b0;
        ref_seg = '0;
    endtask

    task automatic act_clk(logic v);
        if (dir_strap) sclk_a_i = v; else sclk_b_i = v;
    endtask

    task automatic act_din(logic v);
        if (dir_strap) sdi_a = v; else sdi_b = v;
    endtask

    // One shift-clock pulse on the selected side with checks around both edges
    task automatic shift_bit(logic d);
        act_din(d);
        #(CLK_PERIOD/4);
        act_clk(1'b1);
        if (dir_strap) begin
            void'(ref_q.pop_front());
            ref_q.push_back(d);
        end else begin
            void'(ref_q.pop_back());
            ref_q.push_front(d);
        end
        #(CLK_PERIOD/4);
        // R4: no change at the rising edge
        chk_bit("R4 sdo_a hold at rise", sdo_a, ref_do);
        // R5: clock repeated on the far side only
        chk_bit("R5 far clk out high", dir_strap ? sclk_b_o : sclk_a_o, 1'b1);
        chk_bit("R5 near clk out idle", dir_strap ? sclk_a_o : sclk_b_o, 1'b0);
        #(CLK_PERIOD/4);
        act_clk(1'b0);
        ref_do = model_end();
        #(CLK_PERIOD/4);
        // R2 R3 observed through the cascade output
        chk_bit(dir_strap ? "R2 sdo_a after fall" : "R3 sdo_a after fall", sdo_a, ref_do);
        chk_bit("R4 sdo_b equals sdo_a", sdo_b, ref_do);
        // R8
        chk_vec("R8 seg_q unchanged by shift", seg_q, ref_seg);
    endtask

    task automatic load_pos();
        #(CLK_PERIOD/4);
        if (dir_strap) ldp_a_i = 1'b1; else ldp_b_i = 1'b1;
        ref_seg = model_vec();
        #(CLK_PERIOD/4);
        chk_vec("R6 load on ldp rise", seg_q, ref_seg);
        chk_bit("R9 ldp far out", dir_strap ? ldp_b_o : ldp_a_o, 1'b1);
        chk_bit("R9 ldp near idle", dir_strap ? ldp_a_o : ldp_b_o, 1'b0);
        if (dir_strap) ldp_a_i = 1'b0; else ldp_b_i = 1'b0;
        #(CLK_PERIOD/2);
        chk_vec("R6 hold after ldp fall", seg_q, ref_seg);
    endtask

    task automatic load_neg();
        #(CLK_PERIOD/4);
        if (dir_strap) ldn_a_i = 1'b0; else ldn_b_i = 1'b0;
        ref_seg = model_vec();
        #(CLK_PERIOD/4);
        chk_vec("R7 load on ldn fall", seg_q, ref_seg);
        chk_bit("R9 ldn far out", dir_strap ? ldn_b_o : ldn_a_o, 1'b0);
        chk_bit("R9 ldn near idle", dir_strap ? ldn_a_o : ldn_b_o, 1'b1);
        if (dir_strap) ldn_a_i = 1'b1; else ldn_b_i = 1'b1;
        #(CLK_PERIOD/2);
        chk_vec("R7 hold after ldn rise", seg_q, ref_seg);
    endtask

    task automatic mclk_check();
        if (dir_strap) mclk_a_i = 1'b1; else mclk_b_i = 1'b1;
        #(CLK_PERIOD/4);
        chk_bit("R9 mclk far out", dir_strap ? mclk_b_o : mclk_a_o, 1'b1);
        chk_bit("R9 mclk near idle", dir_strap ? mclk_a_o : mclk_b_o, 1'b0);
        if (dir_strap) mclk_a_i = 1'b0; else mclk_b_i = 1'b0;
        #(CLK_PERIOD/4);
        chk_bit("R9 mclk far out low", dir_strap ? mclk_b_o : mclk_a_o, 1'b0);
    endtask

    // R10: toggle every pad of the non-selected side
    task automatic idle_side_noise();
        for (int k = 0; k < 6; k++) begin
            if (dir_strap) begin
                sdi_b = ~sdi_b; sclk_b_i = 1'b1; ldp_b_i = 1'b1; ldn_b_i = 1'b0; mclk_b_i = 1'b1;
            end else begin
                sdi_a = ~sdi_a; sclk_a_i = 1'b1; ldp_a_i = 1'b1; ldn_a_i = 1'b0; mclk_a_i = 1'b1;
            end
            #(CLK_PERIOD/4);
            chk_bit("R10 near clk out", dir_strap ? sclk_a_o : sclk_b_o, 1'b0);
            chk_bit("R10 near mclk out", dir_strap ? mclk_a_o : mclk_b_o, 1'b0);
            chk_bit("R10 near ldn out", dir_strap ? ldn_a_o : ldn_b_o, 1'b1);
            if (dir_strap) begin
                sclk_b_i = 1'b0; ldp_b_i = 1'b0; ldn_b_i = 1'b1; mclk_b_i = 1'b0;
            end else begin
                sclk_a_i = 1'b0; ldp_a_i = 1'b0; ldn_a_i = 1'b1; mclk_a_i = 1'b0;
            end
            #(CLK_PERIOD/4);
            chk_bit("R10 sdo unchanged", sdo_a, ref_do);
            chk_vec("R10 seg_q unchanged", seg_q, ref_seg);
        end
        // chain untouched: a load must still give the model contents
        load_pos();
    endtask

    // R11: strap changes only inside reset
    task automatic reset_with_dir(logic d);
        rst_n = 1'b0;
        #(CLK_PERIOD/4);
        sdi_a = 0; sdi_b = 0;
        dir_strap = d;
        #(CLK_PERIOD/4);
        // R1
        chk_vec("R1 seg_q zero in reset", seg_q, '0);
        chk_bit("R1 sdo_a zero in reset", sdo_a, 1'b0);
        chk_bit("R1 sdo_b zero in reset", sdo_b, 1'b0);
        act_clk(1'b1);
        #(CLK_PERIOD/2);
        act_clk(1'b0);
        #(CLK_PERIOD/2);
        model_clear();
        rst_n = 1'b1;
        #(CLK_PERIOD/2);
    endtask

    task automatic run_side(int seed);
        for (int i = 0; i < N + 7; i++)
            shift_bit(logic'(((i * seed) % 7) < 3));
        load_pos();
        for (int i = 0; i < 9; i++) shift_bit(logic'(i % 2));
        load_neg();
        mclk_check();
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        idle_side_noise();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..all actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; dir_strap = 1;
        sdi_a = 0; sdi_b = 0; sclk_a_i = 0; sclk_b_i = 0;
        ldp_a_i = 0; ldp_b_i = 0; ldn_a_i = 1; ldn_b_i = 1;
        mclk_a_i = 0; mclk_b_i = 0;
        model_clear();
        #(CLK_PERIOD);
        reset_with_dir(1'b1);
        // R1: load right after reset gives zero
        load_pos();
        run_side(3);
        reset_with_dir(1'b0);
        load_neg();
        run_side(5);
        reset_with_dir(1'b1);
        load_neg();
        run_side(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule